// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs whole PHY register transactions on a two-wire management bus. The bus has a clock output `mdc_o` and one bidirectional data line. The pad cell is outside the block, so the data line comes in as three signals: drive value `mdio_o`, drive enable `mdio_oe_o` and receive value `mdio_i`. A host starts a transaction with a one-cycle request that carries a read/write flag, a PHY address, a register address and write data. It then waits for the `done_o` pulse, which marks the point where the read value and the no-response flag become valid.

Every frame is made of bit slots. Each slot lasts three timing units: the data is set up while the clock is low, then the clock is high, then the clock is low again. One timing unit is `CLK_DIV` system clocks. A write drives all 64 slots. A read drives the first 46 slots and then releases the line while the clock is low. The next slot checks the PHY's turnaround bit, and the last 16 slots shift in the data. A final unit with the clock low hands the line back to the host side. A whole transaction therefore lasts 193 timing units.

Top module: `mdio_master`

## Requirements
- R1: Each transaction opens with 32 clock pulses while `mdio_oe_o`=1 and `mdio_o`=1.
- R2: After the preamble, 14 bits are driven MSB first in this order: the start code 01, the op code (10 for a read, 01 for a write), the 5-bit PHY address and the 5-bit register address.
- R3: Every bit slot spans three units of `CLK_DIV` system clocks: setup (`mdc_o`=0), high (`mdc_o`=1) and hold (`mdc_o`=0). `mdio_o` and `mdio_oe_o` change only at the start of a setup unit or of the final unit.
- R4: A write drives the turnaround pattern 10 after the header and then the 16 write-data bits, MSB first, with `mdio_oe_o`=1 throughout.
- R5: A read drops `mdio_oe_o` at the start of slot 46 (counting from 0) while `mdc_o` is low, and keeps it low up to the final unit.
- R6: In a read, `mdio_i` is sampled at the end of the setup unit of slot 47. If it is high, `err_o`=1 and `rdata_o`=0.
- R7: A read without error returns the 16 `mdio_i` values sampled at the end of the setup units of slots 48 to 63, the first sample landing in bit 15.
- R8: After slot 63 the block spends one more unit with `mdc_o`=0, `mdio_oe_o`=1 and `mdio_o`=1 before it completes.
- R9: `req_i` is taken only while `busy_o`=0. `busy_o` is high from the cycle after acceptance for 193*`CLK_DIV` cycles. `done_o` is then high for exactly one cycle, and a request made while busy has no effect on the frame.
- R10: `rdata_o` and `err_o` are updated only at completion and hold their values until the next one. A completed write reports `err_o`=0 and `rdata_o`=0.
- R11: While idle, `mdc_o`=0, `mdio_oe_o`=1 and `mdio_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register address |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| err_o | output | 1 | PHY did not answer the last read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe_o | output | 1 | Data line drive enable (1 = host to PHY) |
| mdio_i | input | 1 | Data line receive value |

## Verification
Counting from the edge that accepts a request, timing unit u is visible on the bus from cycle u*`CLK_DIV` to (u+1)*`CLK_DIV`-1, and `done_o` is due together with fresh `rdata_o` and `err_o` in cycle 193*`CLK_DIV`. The bench keeps a cycle counter from acceptance and derives the unit, slot and phase from it. At each falling edge it compares the bus and handshake against a frame built separately from the request fields. As a PHY model, it drives `mdio_i` for the slot the counter points at, so each sample point sees a value that is already stable. Results are checked again after idle cycles and after requests made while busy.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 14;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + 2 + DATA_W;
  localparam int REL_BIT    = PRE_BITS + HDR_BITS;
  localparam int ERR_BIT    = REL_BIT + 1;
  localparam int DAT_BIT    = REL_BIT + 2;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;

  typedef enum logic [1:0] {PH_SETUP, PH_HIGH, PH_HOLD} phase_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] reg_a,
    input logic [DATA_W-1:0] wd
  );
    return {{PRE_BITS{1'b1}}, SOF_CODE, (rd ? OP_RD : OP_WR), phy, reg_a, TA_WR, wd};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else if (en_i)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_master_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int REL   = REL_BIT,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [NBITS-1:0] frame_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fin_o,
  output logic             samp_o,
  output logic             rd_o,
  output logic [IW-1:0]    idx_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o
);
  logic             busy_q, fin_q, rd_q, done_q;
  logic [IW-1:0]    idx_q;
  phase_e           ph_q;
  logic [NBITS-1:0] sr_q;
  logic             active, rx_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      ph_q   <= PH_SETUP;
      sr_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
      rd_q   <= rd_i;
      idx_q  <= '0;
      ph_q   <= PH_SETUP;
      sr_q   <= frame_i;
    end else if (busy_q && tick_i) begin
      if (fin_q) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b0;
      end else begin
        unique case (ph_q)
          PH_SETUP: ph_q <= PH_HIGH;
          PH_HIGH:  ph_q <= PH_HOLD;
          default: begin
            ph_q <= PH_SETUP;
            if (idx_q == IW'(NBITS - 1)) fin_q <= 1'b1;
            else begin
              idx_q <= idx_q + 1'b1;
              sr_q  <= {sr_q[NBITS-2:0], 1'b0};
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fin_o;
  end

  assign active    = busy_q && !fin_q;
  assign rx_win    = active && rd_q && (idx_q >= IW'(REL));
  assign fin_o     = busy_q && tick_i && fin_q;
  assign samp_o    = active && tick_i && rd_q && (ph_q == PH_SETUP);
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rd_o      = rd_q;
  assign idx_o     = idx_q;
  assign mdc_o     = active && (ph_q == PH_HIGH);
  assign mdio_oe_o = !rx_win;
  assign mdio_o    = rx_win ? 1'b0 : (active ? sr_q[NBITS-1] : 1'b1);

  // R3
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o) && $stable(mdio_oe_o));
  // R5
  release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> !mdc_o && !$past(mdc_o));
  // R8
  reclaim_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdc_o && !$past(mdc_o));
  // R11
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o && mdio_oe_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_master_pkg::*;
#(
  parameter int IW    = 6,
  parameter int EBIT  = ERR_BIT,
  parameter int DBIT  = DAT_BIT,
  parameter int DW    = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          samp_i,
  input  logic [IW-1:0] idx_i,
  input  logic          mdio_i,
  input  logic          fin_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  logic          err_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      sh_q  <= '0;
    end else if (start_i) begin
      err_q <= 1'b0;
      sh_q  <= '0;
    end else if (samp_i) begin
      if (idx_i == IW'(EBIT)) err_q <= mdio_i;
      if (idx_i >= IW'(DBIT)) sh_q  <= {sh_q[DW-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else if (fin_i) begin
      rdata_o <= (rd_i && !err_q) ? sh_q : '0;
      err_o   <= rd_i && err_q;
    end
  end

  // R6
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fin_i) |-> $stable(rdata_o) && $stable(err_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_phy_i,
  input  logic [ADDR_W-1:0] req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int IW = $clog2(FRAME_BITS);

  logic          start, tick, fin, samp, rd;
  logic [IW-1:0] idx;

  assign start = req_i && !busy_o;

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i, .rst_ni, .clr_i(start), .en_i(busy_o), .tick_o(tick)
  );

  mdio_frame_seq #(.NBITS(FRAME_BITS), .REL(REL_BIT)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .rd_i(req_rd_i),
    .frame_i(build_frame(req_rd_i, req_phy_i, req_reg_i, req_wdata_i)),
    .tick_i(tick), .busy_o, .done_o, .fin_o(fin), .samp_o(samp), .rd_o(rd),
    .idx_o(idx), .mdc_o, .mdio_o, .mdio_oe_o
  );

  mdio_rx_capture #(.IW(IW), .EBIT(ERR_BIT), .DBIT(DAT_BIT), .DW(DATA_W)) u_rx (
    .clk_i, .rst_ni, .start_i(start), .samp_i(samp), .idx_i(idx), .mdio_i,
    .fin_i(fin), .rd_i(rd), .rdata_o, .err_o
  );

  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int D     = 3;
  localparam int UNITS = 193;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_rd_i = 1'b0;
  logic [4:0]  req_phy_i = '0, req_reg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rdata_o;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  mdio_master #(.CLK_DIV(D)) dut_i (
    .clk_i, .rst_ni, .req_i, .req_rd_i, .req_phy_i, .req_reg_i, .req_wdata_i,
    .busy_o, .done_o, .rdata_o, .err_o, .mdc_o, .mdio_o, .mdio_oe_o, .mdio_i
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(tag, "R11 idle mdc", 32'(mdc_o), 0);
    chk(tag, "R11 idle oe", 32'(mdio_oe_o), 1);
    chk(tag, "R11 idle mdio", 32'(mdio_o), 1);
    chk(tag, "idle busy", 32'(busy_o), 0);
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rdat,
                         input bit inj, input bit poke);
    bit fb[$];
    fb = {};
    for (int i = 0; i < 32; i++) fb.push_back(1'b1);
    fb.push_back(1'b0); fb.push_back(1'b1);
    if (rd) begin fb.push_back(1'b1); fb.push_back(1'b0); end
    else    begin fb.push_back(1'b0); fb.push_back(1'b1); end
    for (int i = 4; i >= 0; i--) fb.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) fb.push_back(ra[i]);
    if (!rd) begin
      fb.push_back(1'b1); fb.push_back(1'b0);
      for (int i = 15; i >= 0; i--) fb.push_back(wd[i]);
    end

    @(negedge clk_i);
    req_i = 1'b1; req_rd_i = rd; req_phy_i = phy; req_reg_i = ra; req_wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    for (int n = 0; n <= UNITS * D + 1; n++) begin
      int u, b, p;
      bit oe_exp;
      if (n > 0) @(negedge clk_i);
      u = n / D; b = u / 3; p = u % 3;
      // PHY model
      if (rd && u < UNITS - 1 && b >= 46) begin
        if (b == 46)      mdio_i = 1'b1;
        else if (b == 47) mdio_i = inj;
        else              mdio_i = rdat[63 - b];
      end else mdio_i = 1'b1;
      // R9: requests while busy must not disturb the frame
      if (poke && n == 30) begin
        req_i = 1'b1; req_rd_i = !rd; req_phy_i = ~phy; req_reg_i = ~ra; req_wdata_i = ~wd;
      end
      if (poke && n == 36) req_i = 1'b0;

      if (n < UNITS * D) begin
        chk("R9", "busy during frame", 32'(busy_o), 1);
        chk("R9", "done during frame", 32'(done_o), 0);
        if (u < UNITS - 1) begin
          chk("R3", "mdc phase", 32'(mdc_o), 32'(p == 1));
          oe_exp = !(rd && b >= 46);
          chk("R5", "direction", 32'(mdio_oe_o), 32'(oe_exp));
          if (oe_exp)
            chk(b < 32 ? "R1" : (b < 46 ? "R2" : "R4"), "mdio bit",
                32'(mdio_o), 32'(fb[b]));
        end else begin
          chk("R8", "final mdc", 32'(mdc_o), 0);
          chk("R8", "final oe", 32'(mdio_oe_o), 1);
          chk("R8", "final mdio", 32'(mdio_o), 1);
        end
      end else if (n == UNITS * D) begin
        chk("R9", "busy at end", 32'(busy_o), 0);
        chk("R9", "done pulse", 32'(done_o), 1);
        chk("R6", "err flag", 32'(err_o), 32'(rd && inj));
        chk(rd ? "R7" : "R10", "rdata", 32'(rdata_o),
            32'((rd && !inj) ? rdat : 16'h0));
      end else begin
        chk("R9", "done width", 32'(done_o), 0);
        chk("R10", "rdata after done", 32'(rdata_o),
            32'((rd && !inj) ? rdat : 16'h0));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11", "reset mdc", 32'(mdc_o), 0);
    chk("R10", "reset rdata", 32'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R11");
    chk("R9", "reset done", 32'(done_o), 0);
    chk("R10", "reset err", 32'(err_o), 0);

    run_txn(1'b0, 5'h01, 5'h00, 16'hA55A, 16'h0000, 1'b0, 1'b0);
    run_txn(1'b1, 5'h1F, 5'h11, 16'h0000, 16'hC3A5, 1'b0, 1'b0);
    repeat (20) @(negedge clk_i);
    check_idle("R11");
    chk("R10", "held rdata", 32'(rdata_o), 32'h0000C3A5);
    chk("R10", "held err", 32'(err_o), 0);
    run_txn(1'b1, 5'h0A, 5'h03, 16'h0000, 16'hFFFF, 1'b1, 1'b0);
    repeat (5) @(negedge clk_i);
    chk("R6", "held err", 32'(err_o), 1);
    chk("R6", "held zero", 32'(rdata_o), 0);
    run_txn(1'b0, 5'h10, 5'h1F, 16'h0001, 16'h0000, 1'b0, 1'b1);
    run_txn(1'b1, 5'h00, 5'h00, 16'h0000, 16'h8001, 1'b0, 1'b1);
    run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h7FFE, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    check_idle("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule